// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Dual Clear Sources

This block is an 8-bit up-counter driven by a selectable clock divider. It has two 8-bit compare registers. Whenever the incremented count equals a nonzero compare value, the block raises a one-cycle request pulse for that compare. Either compare, or both, can be set to return the counter to zero when it is reached. When both clear sources are enabled, the smaller compare value decides which one clears the counter.

Software reaches the block through a byte-wide register port. A write is taken on a clock edge, and a read returns data combinationally from the same address bus. The register map:

| Address | Contents |
|---|---|
| 0 | Compare 0 |
| 1 | Compare 1 |
| 2 | Divider select |
| 3 | Clear control |
| 4 | Control, holding the enable and overflow bits |

The counter value and the two request pulses are brought out as ports.

Top module: `dual_clear_timer`

## Requirements
- R1: The counter advances by one every 8 clocks when divider select (address 2, bits [1:0]) is 0, 1 or 2, and every 16 clocks when it is 3. The first advance comes that many clocks after the edge that enables counting.
- R2: Counting runs only while bit 3 of the control register (address 4) is 1. While it is 0 the counter holds its value and the divider phase stays at zero.
- R3: On an advance where the incremented value equals compare 0 (address 0) and that value is nonzero, `match0_o` is high for exactly the one cycle in which the new count appears. Compare 1 (address 1) behaves the same way on `match1_o`.
- R4: With clear-control (address 3) bit 1 set, reaching compare 0 loads zero into the counter instead of the compare value.
- R5: Clear-control bits [3:2] equal to 2'b10 make reaching compare 1 load zero. Any other value of these bits, including 2'b11, leaves compare 1 without a clear effect.
- R6: With both clear sources enabled, only compare 1 clears when it is strictly less than compare 0. Otherwise only compare 0 clears, and equal values count as compare 0.
- R7: When the clear source in effect has a compare value of zero, every advance leaves the counter at zero.
- R8: An advance from 0xFF with no clear wraps the counter to zero and sets control bit 2. The bit stays set until software writes it to 0. If such a wrap falls in the same cycle as a control write, the bit still ends set.
- R9: Writing the divider-select register restarts the divider phase at zero, so the next advance comes a full division period after that write.
- R10: After reset every register and the counter read zero, both pulses are low, and reads of addresses 5 to 7 return zero. Readback places the divider select in bits [1:0], clear control in bits [3:1], and enable and overflow in bits 3 and 2 of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| count_o | output | 8 | Current counter value |
| match0_o | output | 1 | One-cycle request on reaching compare 0 |
| match1_o | output | 1 | One-cycle request on reaching compare 1 |

## Verification
Two events can fall in the same cycle: the counter wrapping past 0xFF, which sets the overflow bit, and a software write to the control register that clears that bit. The bench runs the counter to 0xFF and times a control write carrying overflow 0 so that it lands on the exact edge of the wrapping advance. The overflow bit must read 1 afterwards, and it must read 0 after a second write in a quiet cycle. A second coincidence is both compares matching on the same advance with equal values, where both pulses must appear and compare 0 must do the clearing.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic [2:0] {
        A_CMP0 = 3'd0,
        A_CMP1 = 3'd1,
        A_DSEL = 3'd2,
        A_CLRC = 3'd3,
        A_CTRL = 3'd4
    } reg_addr_e;

    localparam int unsigned CTRL_EN_BIT  = 3;
    localparam int unsigned CTRL_OVF_BIT = 2;
    localparam int unsigned CLR0_BIT     = 1;
endpackage

// File: rtl/dct_divider.sv
module dct_divider #(
    parameter int unsigned LO_LOG2 = 3,
    parameter int unsigned HI_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic slow_sel,
    output logic tick
);
    localparam int unsigned PW = HI_LOG2;
    localparam logic [PW-1:0] LAST_LO = PW'((1 << LO_LOG2) - 1);
    localparam logic [PW-1:0] LAST_HI = PW'((1 << HI_LOG2) - 1);

    logic [PW-1:0] phase_d, phase_q;
    logic [PW-1:0] last;

    always_comb begin
        last    = slow_sel ? LAST_HI : LAST_LO;
        tick    = run && (phase_q == last);
        phase_d = phase_q + PW'(1);
        if (!run || restart || tick) begin
            phase_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // R1: an advance is never followed by another on the next clock
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R9: a divider-select write leaves the phase at zero
    assert_phase_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));
    // R2: a stopped timer keeps its phase at zero
    assert_phase_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_q == '0));
endmodule

// File: rtl/dct_clear_pick.sv
module dct_clear_pick #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    input  logic         en0,
    input  logic         en1,
    output logic         active,
    output logic [W-1:0] limit
);
    logic pick1;

    always_comb begin
        pick1  = en1 && (!en0 || (cmp1 < cmp0));
        active = en0 || en1;
        limit  = pick1 ? cmp1 : cmp0;
    end
endmodule

// File: rtl/dual_clear_timer.sv
module dual_clear_timer #(
    parameter int unsigned CW      = 8,
    parameter int unsigned AW      = 3,
    parameter int unsigned LO_LOG2 = 3,
    parameter int unsigned HI_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    output logic [CW-1:0] count_o,
    output logic          match0_o,
    output logic          match1_o
);
    import dct_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cmp0;
        logic [CW-1:0] cmp1;
        logic [1:0]    dsel;
        logic [2:0]    clrc;   // {clr1_hi, clr1_lo, clr0}
        logic          en;
        logic          ovf;
        logic [CW-1:0] cnt;
        logic          m0;
        logic          m1;
    } state_t;

    state_t s_d, s_q;

    logic          tick;
    logic          dsel_wr;
    logic          clr_active;
    logic [CW-1:0] clr_limit;
    logic          clr0_en, clr1_en;
    logic [CW:0]   inc;

    assign clr0_en = s_q.clrc[0];
    assign clr1_en = (s_q.clrc[2:1] == 2'b10);
    assign dsel_wr = wr_en && (addr == AW'(A_DSEL));

    dct_divider #(.LO_LOG2(LO_LOG2), .HI_LOG2(HI_LOG2)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (s_q.en),
        .restart  (dsel_wr),
        .slow_sel (s_q.dsel == 2'b11),
        .tick     (tick)
    );

    dct_clear_pick #(.W(CW)) u_pick (
        .cmp0   (s_q.cmp0),
        .cmp1   (s_q.cmp1),
        .en0    (clr0_en),
        .en1    (clr1_en),
        .active (clr_active),
        .limit  (clr_limit)
    );

    always_comb begin
        s_d    = s_q;
        s_d.m0 = 1'b0;
        s_d.m1 = 1'b0;
        inc    = {1'b0, s_q.cnt} + {{CW{1'b0}}, 1'b1};

        if (wr_en) begin
            case (addr)
                AW'(A_CMP0): s_d.cmp0 = wr_data;
                AW'(A_CMP1): s_d.cmp1 = wr_data;
                AW'(A_DSEL): s_d.dsel = wr_data[1:0];
                AW'(A_CLRC): s_d.clrc = wr_data[3:1];
                AW'(A_CTRL): begin
                    s_d.en  = wr_data[CTRL_EN_BIT];
                    s_d.ovf = wr_data[CTRL_OVF_BIT];
                end
                default: ;
            endcase
        end

        if (tick) begin
            s_d.m0 = (s_q.cmp0 != '0) && (inc == {1'b0, s_q.cmp0});
            s_d.m1 = (s_q.cmp1 != '0) && (inc == {1'b0, s_q.cmp1});
            if (clr_active && ((clr_limit == '0) || (inc == {1'b0, clr_limit}))) begin
                s_d.cnt = '0;
            end else begin
                s_d.cnt = inc[CW-1:0];
                if (inc[CW]) s_d.ovf = 1'b1;
            end
        end

        rd_data = '0;
        case (addr)
            AW'(A_CMP0): rd_data = s_q.cmp0;
            AW'(A_CMP1): rd_data = s_q.cmp1;
            AW'(A_DSEL): rd_data[1:0] = s_q.dsel;
            AW'(A_CLRC): rd_data[3:1] = s_q.clrc;
            AW'(A_CTRL): begin
                rd_data[CTRL_EN_BIT]  = s_q.en;
                rd_data[CTRL_OVF_BIT] = s_q.ovf;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o  = s_q.cnt;
    assign match0_o = s_q.m0;
    assign match1_o = s_q.m1;

    // R2: a stopped timer does not change its count
    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.en |=> $stable(count_o));
    // R3: request pulses last a single cycle
    assert_m0_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match0_o |=> !match0_o);
    assert_m1_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match1_o |=> !match1_o);
    // R7: a zero limit on the clear source in effect pins the count at zero
    assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_active && (clr_limit == '0)) |=> (count_o == '0));
    // R8: wrapping with no clear sets the overflow bit, even against a write
    assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_active && (count_o == '1)) |=> (s_q.ovf && (count_o == '0)));
endmodule

// File: tb/dual_clear_timer_tb.sv
module dual_clear_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] count_o;
    logic       match0_o, match1_o;

    int n_cmp = 0;
    int n_bad = 0;
    int m0c = 0;
    int m1c = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    dual_clear_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .count_o(count_o), .match0_o(match0_o), .match1_o(match1_o)
    );

    always @(negedge clk) begin
        if (match0_o) m0c++;
        if (match1_o) m1c++;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  clr;
        logic [7:0]  c0;
        logic [7:0]  c1;
        logic [15:0] n;
        logic [7:0]  ecnt;
        logic [7:0]  em0;
        logic [7:0]  em1;
        logic        eovf;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h00, 8'd5,   8'd9, 16'd12,  8'd12, 8'd1, 8'd0 + 8'd1, 1'b0}, // R1 R3 free run
        '{2'd3, 8'h02, 8'd4,   8'd2, 16'd10,  8'd2,  8'd2, 8'd3, 1'b0},        // R1 R4 slow, clr0
        '{2'd1, 8'h08, 8'd3,   8'd5, 16'd7,   8'd2,  8'd1, 8'd1, 1'b0},        // R5 clr1 only
        '{2'd2, 8'h0A, 8'd6,   8'd4, 16'd9,   8'd1,  8'd0, 8'd2, 1'b0},        // R6 cmp1 smaller
        '{2'd0, 8'h0A, 8'd3,   8'd5, 16'd7,   8'd1,  8'd2, 8'd0, 1'b0},        // R6 cmp0 smaller
        '{2'd0, 8'h0A, 8'd4,   8'd4, 16'd5,   8'd1,  8'd1, 8'd1, 1'b0},        // R6 tie
        '{2'd0, 8'h0C, 8'd200, 8'd3, 16'd5,   8'd5,  8'd0, 8'd1, 1'b0},        // R5 bits 11 inert
        '{2'd0, 8'h02, 8'd0,   8'd1, 16'd6,   8'd0,  8'd0, 8'd6, 1'b0},        // R7 zero limit
        '{2'd0, 8'h00, 8'd0,   8'd0, 16'd258, 8'd2,  8'd0, 8'd0, 1'b1}         // R8 wrap
    };

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [7:0] r;
        int div;

        // R10 reset state
        do_reset();
        #1;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            check("R10 reset readback", r, 0);
        end
        check("R10 reset count", count_o, 0);
        check("R10 reset pulses", {match0_o, match1_o}, 0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(3'd0, VEC[i].c0);
            wr(3'd1, VEC[i].c1);
            wr(3'd2, {6'd0, VEC[i].sel});
            wr(3'd3, VEC[i].clr);
            m0c = 0; m1c = 0;
            wr(3'd4, 8'h08);
            div = (VEC[i].sel == 2'd3) ? 16 : 8;
            repeat (int'(VEC[i].n) * div) @(posedge clk);
            @(negedge clk);
            #1;
            check($sformatf("R1 R4 R5 R6 R7 vec%0d count", i), count_o, VEC[i].ecnt);
            check($sformatf("R3 vec%0d match0 pulses", i), m0c, VEC[i].em0);
            check($sformatf("R3 vec%0d match1 pulses", i), m1c, VEC[i].em1);
            rd(3'd4, r);
            check($sformatf("R8 vec%0d overflow bit", i), r[2], VEC[i].eovf);
        end

        // R9 divider restart on select write
        do_reset();
        wr(3'd4, 8'h08);
        repeat (5) @(posedge clk);
        wr(3'd2, 8'h00);
        repeat (7) @(posedge clk);
        @(negedge clk); #1;
        check("R9 no advance before full period after restart", count_o, 0);
        @(posedge clk); @(negedge clk); #1;
        check("R9 advance one period after restart", count_o, 1);

        // R2 stopping holds the count
        do_reset();
        wr(3'd4, 8'h08);
        repeat (24) @(posedge clk);
        @(negedge clk); #1;
        check("R2 count before stop", count_o, 3);
        wr(3'd4, 8'h00);
        repeat (40) @(posedge clk);
        @(negedge clk); #1;
        check("R2 count held while stopped", count_o, 3);
        rd(3'd4, r);
        check("R2 enable bit readback", r, 0);

        // R8 wrap coinciding with a control write
        do_reset();
        wr(3'd4, 8'h08);
        repeat (2047) @(posedge clk);
        #1;
        check("R8 count before wrap", count_o, 255);
        wr(3'd4, 8'h08);
        #1;
        rd(3'd4, r);
        check("R8 overflow kept over same-cycle write", r, 8'h0C);
        check("R8 count wrapped", count_o, 0);
        wr(3'd4, 8'h08);
        #1;
        rd(3'd4, r);
        check("R8 overflow cleared by write", r, 8'h08);

        // R10 readback layout
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        rd(3'd2, r);
        check("R10 divider select readback", r, 8'h03);
        rd(3'd3, r);
        check("R10 clear control readback", r, 8'h0E);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule